// File: doc/BRIEF.md
# Core-Socket Request/Response Memory Slave

This block is the slave end of a point-to-point, one-way, synchronous core socket. A small word-addressed memory sits behind it. The master drives a command and an address and holds them until the slave accepts the request. Reads end with a response phase that returns a status code and the read data. Writes are posted: the slave takes the address and the data and never answers.

With `DHS_EN` set (the default), write data travels in its own phase. This phase comes after the write request is accepted. The master marks the data with a valid strobe and the slave takes it with a data-accept. With `DHS_EN` cleared, the write data is taken in the same cycle as the request.

The phases of any transfer run in a fixed order: request, then data, then response. The slave takes no new request while write data or a read response is still pending. As a result there is never more than one read outstanding.

Top module: `core_sock_slave`

## Requirements
- R1: Commands are 3 bits wide: 0 is idle, 1 is write, 2 is read, and every other value is treated as idle. An idle-class command is never accepted and leaves the outputs and the memory unchanged.
- R2: When the slave is free, `s_cmd_accept_o` is high in the same cycle as a write or read command. The master holds the command and address until that cycle.
- R3: In the cycle after a read is accepted, the response field is 1 (data valid) and `s_data_o` carries the stored word.
- R4: A response and its data stay unchanged for as long as `m_resp_accept_i` is low. In the cycle after the master accepts, the response field returns to 0 (none) and the data returns to 0.
- R5: A read to an address at or beyond `MEM_DEPTH` returns response 3 (error) with zero data.
- R6: A write never produces a response phase: the response field stays 0.
- R7: With the data phase enabled, write data is taken in a later cycle than its request. `s_data_accept_o` is high exactly when `m_data_valid_i` is high while write data is pending, and the memory is updated at that edge.
- R8: While write data or a read response is pending, no request is accepted. Data is never accepted while a response is pending.
- R9: A data strobe with no write pending is not accepted and does not change the memory.
- R10: A write to an address at or beyond `MEM_DEPTH` is dropped and does not alias onto an in-range word.
- R11: After reset, the response field and the read data are 0 and every memory word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_cmd_i | input | 3 | Master command |
| m_addr_i | input | ADDR_W | Master word address |
| m_data_i | input | DATA_W | Master write data |
| m_data_valid_i | input | 1 | Write data valid strobe |
| m_resp_accept_i | input | 1 | Master takes the response |
| s_cmd_accept_o | output | 1 | Request accepted |
| s_data_accept_o | output | 1 | Write data accepted |
| s_resp_o | output | 3 | Response code |
| s_data_o | output | DATA_W | Read data |

## Verification
The hardest cases to reach are the ordering stalls. In these a new request sits on the bus while write data is still pending, or while a read response is being held. The bench creates both. In the first, it issues a write request and then presents a read while the data strobe is held low for several cycles. In the second, it leaves a read response unaccepted and keeps a second read on the command lines. In both cases it checks that the request is refused and that the held response does not move. Out-of-range writes are checked by reading back the word they would alias to.

// File: rtl/sock_pkg.sv
package sock_pkg;
  localparam int CMD_W  = 3;
  localparam int RESP_W = 3;

  localparam logic [CMD_W-1:0] CMD_IDLE = 3'd0;
  localparam logic [CMD_W-1:0] CMD_WR   = 3'd1;
  localparam logic [CMD_W-1:0] CMD_RD   = 3'd2;

  localparam logic [RESP_W-1:0] RESP_NONE = 3'd0;
  localparam logic [RESP_W-1:0] RESP_DVA  = 3'd1;
  localparam logic [RESP_W-1:0] RESP_ERR  = 3'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WDATA = 2'd1,
    ST_RESP  = 2'd2
  } phase_e;
endpackage

// File: rtl/sock_mem.sv
module sock_mem #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MEM_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_hit_o
);
  localparam int IDX_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_DEPTH);

  logic [DATA_W-1:0] mem_q [MEM_DEPTH];
  logic              wr_hit;

  assign wr_hit   = wr_addr_i < LIMIT;
  assign rd_hit_o = rd_addr_i < LIMIT;
  assign rd_data_o = rd_hit_o ? mem_q[rd_addr_i[IDX_W-1:0]] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i && wr_hit) begin
      mem_q[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
    end
  end

  // out-of-range read must come back empty
  a_r5_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit_o |-> rd_data_o == '0);
endmodule

// File: rtl/sock_phase_ctl.sv
module sock_phase_ctl
  import sock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter bit DHS_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic              resp_acc_i,
  output logic              cmd_acc_o,
  output logic              data_acc_o,
  output logic              rd_fire_o,
  output logic              wr_fire_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  phase_e state_q, state_d;
  logic   is_wr, is_rd, idle;

  assign is_wr = cmd_i == CMD_WR;
  assign is_rd = cmd_i == CMD_RD;
  assign idle  = state_q == ST_IDLE;

  assign cmd_acc_o = idle && (is_wr || is_rd);
  assign rd_fire_o = idle && is_rd;

  generate
    if (DHS_EN) begin : g_dhs
      logic [ADDR_W-1:0] addr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           addr_q <= '0;
        else if (idle && is_wr) addr_q <= addr_i;
      end
      assign data_acc_o = (state_q == ST_WDATA) && data_valid_i;
      assign wr_fire_o  = data_acc_o;
      assign wr_addr_o  = addr_q;

      // data phase only ever follows an accepted write request
      a_r7_data_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(state_q == ST_WDATA) |-> $past(cmd_acc_o && is_wr));
    end else begin : g_flat
      assign data_acc_o = idle && is_wr;
      assign wr_fire_o  = data_acc_o;
      assign wr_addr_o  = addr_i;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (is_rd)                state_d = ST_RESP;
        else if (is_wr && DHS_EN) state_d = ST_WDATA;
      end
      ST_WDATA: if (data_valid_i) state_d = ST_IDLE;
      ST_RESP:  if (resp_acc_i)   state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  a_r2_accept_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fire_o |=> !cmd_acc_o);
endmodule

// File: rtl/sock_resp_reg.sv
module sock_resp_reg
  import sock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              acc_i,
  output logic [RESP_W-1:0] resp_o,
  output logic [DATA_W-1:0] data_o
);
  logic [RESP_W-1:0] resp_q;
  logic [DATA_W-1:0] data_q;
  logic              busy;

  assign busy   = resp_q != RESP_NONE;
  assign resp_o = resp_q;
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= RESP_NONE;
      data_q <= '0;
    end else if (load_i) begin
      resp_q <= hit_i ? RESP_DVA : RESP_ERR;
      data_q <= hit_i ? data_i : '0;
    end else if (busy && acc_i) begin
      resp_q <= RESP_NONE;
      data_q <= '0;
    end
  end

  a_r1_resp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_q == RESP_NONE || resp_q == RESP_DVA || resp_q == RESP_ERR);
  a_r3_resp_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !acc_i) |=> ($stable(resp_q) && $stable(data_q)));
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && acc_i) |=> (resp_q == RESP_NONE && data_q == '0));
endmodule

// File: rtl/core_sock_slave.sv
module core_sock_slave
  import sock_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MEM_DEPTH = 16,
  parameter bit DHS_EN    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        m_cmd_i,
  input  logic [ADDR_W-1:0] m_addr_i,
  input  logic [DATA_W-1:0] m_data_i,
  input  logic              m_data_valid_i,
  input  logic              m_resp_accept_i,
  output logic              s_cmd_accept_o,
  output logic              s_data_accept_o,
  output logic [2:0]        s_resp_o,
  output logic [DATA_W-1:0] s_data_o
);
  logic              rd_fire, wr_fire, rd_hit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] rd_data;

  sock_phase_ctl #(.ADDR_W(ADDR_W), .DHS_EN(DHS_EN)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (m_cmd_i),
    .addr_i       (m_addr_i),
    .data_valid_i (m_data_valid_i),
    .resp_acc_i   (m_resp_accept_i),
    .cmd_acc_o    (s_cmd_accept_o),
    .data_acc_o   (s_data_accept_o),
    .rd_fire_o    (rd_fire),
    .wr_fire_o    (wr_fire),
    .wr_addr_o    (wr_addr)
  );

  sock_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_fire),
    .wr_addr_i (wr_addr),
    .wr_data_i (m_data_i),
    .rd_addr_i (m_addr_i),
    .rd_data_o (rd_data),
    .rd_hit_o  (rd_hit)
  );

  sock_resp_reg #(.DATA_W(DATA_W)) u_resp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rd_fire),
    .hit_i  (rd_hit),
    .data_i (rd_data),
    .acc_i  (m_resp_accept_i),
    .resp_o (s_resp_o),
    .data_o (s_data_o)
  );

  a_r8_no_req_during_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_resp_o != RESP_NONE) |-> !s_cmd_accept_o);
  a_r8_no_data_during_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_data_accept_o |-> (s_resp_o == RESP_NONE));
  a_r6_write_posted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_cmd_accept_o && m_cmd_i == CMD_WR) |=> (s_resp_o == RESP_NONE));
endmodule

// File: tb/core_sock_slave_test.sv
module core_sock_slave_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  cmd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [2:0]  resp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 8'h00, 32'hDEAD_BEEF, 3'd0},
    '{3'd1, 8'h01, 32'h1234_5678, 3'd0},
    '{3'd1, 8'h0F, 32'hA5A5_A5A5, 3'd0},
    '{3'd2, 8'h00, 32'hDEAD_BEEF, 3'd1},
    '{3'd2, 8'h01, 32'h1234_5678, 3'd1},
    '{3'd2, 8'h0F, 32'hA5A5_A5A5, 3'd1},
    '{3'd2, 8'h10, 32'h0000_0000, 3'd3},
    '{3'd5, 8'h02, 32'h0BAD_0BAD, 3'd0},
    '{3'd2, 8'h02, 32'h0000_0000, 3'd1},
    '{3'd7, 8'h01, 32'hFFFF_FFFF, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  m_cmd = 3'd0;
  logic [7:0]  m_addr = '0;
  logic [31:0] m_data = '0;
  logic        m_dval = 1'b0;
  logic        m_racc = 1'b0;
  logic        s_cacc, s_dacc;
  logic [2:0]  s_resp;
  logic [31:0] s_data;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_sock_slave uut (
    .clk_i(clk), .rst_ni(rst_n),
    .m_cmd_i(m_cmd), .m_addr_i(m_addr), .m_data_i(m_data),
    .m_data_valid_i(m_dval), .m_resp_accept_i(m_racc),
    .s_cmd_accept_o(s_cacc), .s_data_accept_o(s_dacc),
    .s_resp_o(s_resp), .s_data_o(s_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input int gap);
    @(negedge clk);
    m_cmd = 3'd1; m_addr = a; m_data = '0;
    #1;
    chk("R2 write accept", 32'(s_cacc), 1);
    chk("R7 no data with request", 32'(s_dacc), 0);
    @(posedge clk);
    @(negedge clk);
    m_cmd = 3'd0;
    for (int i = 0; i < gap; i++) begin
      #1 chk("R7 data waits for strobe", 32'(s_dacc), 0);
      @(negedge clk);
    end
    m_dval = 1'b1; m_data = d;
    #1;
    chk("R7 data accept", 32'(s_dacc), 1);
    @(posedge clk);
    @(negedge clk);
    m_dval = 1'b0;
    #1;
    chk("R6 posted write no response", 32'(s_resp), 0);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [2:0] er, input logic [31:0] ed,
                         input int hold);
    @(negedge clk);
    m_cmd = 3'd2; m_addr = a;
    #1;
    chk("R2 read accept", 32'(s_cacc), 1);
    @(posedge clk);
    @(negedge clk);
    m_cmd = 3'd0;
    #1;
    chk("R3 R5 response code", 32'(s_resp), 32'(er));
    chk("R3 R5 response data", s_data, ed);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      #1;
      chk("R4 response held", 32'(s_resp), 32'(er));
      chk("R4 data held", s_data, ed);
    end
    m_racc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_racc = 1'b0;
    #1;
    chk("R4 response cleared", 32'(s_resp), 0);
    chk("R4 data cleared", s_data, 0);
  endtask

  task automatic do_idle_cmd(input logic [2:0] c, input logic [7:0] a);
    @(negedge clk);
    m_cmd = c; m_addr = a;
    #1;
    chk("R1 idle-class command refused", 32'(s_cacc), 0);
    @(posedge clk);
    @(negedge clk);
    m_cmd = 3'd0;
    #1;
    chk("R1 no response after idle-class command", 32'(s_resp), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    #1;
    chk("R11 reset response", 32'(s_resp), 0);
    chk("R11 reset data", s_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    do_read(8'h05, 3'd1, 32'h0, 0);   // R11 memory cleared

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].cmd == 3'd1)      do_write(VEC[v].addr, VEC[v].data, 0);
      else if (VEC[v].cmd == 3'd2) do_read(VEC[v].addr, VEC[v].resp, VEC[v].data, 0);
      else                         do_idle_cmd(VEC[v].cmd, VEC[v].addr);
    end
    // idle-class commands above wrote nothing (R1)
    do_read(8'h02, 3'd1, 32'h0, 0);

    // R8: read refused while write data pending
    @(negedge clk);
    m_cmd = 3'd1; m_addr = 8'h03;
    @(posedge clk);
    @(negedge clk);
    m_cmd = 3'd2; m_addr = 8'h00;
    #1;
    chk("R8 no request while data pending", 32'(s_cacc), 0);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R8 still refused, no response", 32'(s_resp), 0);
    m_cmd = 3'd0; m_dval = 1'b1; m_data = 32'hCAFE_0003;
    @(posedge clk);
    @(negedge clk);
    m_dval = 1'b0;
    do_read(8'h03, 3'd1, 32'hCAFE_0003, 0);

    // R7: data strobe delayed
    do_write(8'h04, 32'h4444_0004, 3);
    do_read(8'h04, 3'd1, 32'h4444_0004, 0);

    // R4/R8: response held while another read waits
    @(negedge clk);
    m_cmd = 3'd2; m_addr = 8'h01;
    @(posedge clk);
    @(negedge clk);
    m_addr = 8'h00;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R8 no request during response", 32'(s_cacc), 0);
      chk("R4 held during stall", s_data, 32'h1234_5678);
      @(negedge clk);
    end
    m_cmd = 3'd0;
    m_racc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_racc = 1'b0;
    do_read(8'h0F, 3'd3 - 3'd2, 32'hA5A5_A5A5, 2);

    // R9: stray data strobe
    @(negedge clk);
    m_dval = 1'b1; m_data = 32'hBADD_A7A0;
    #1;
    chk("R9 stray strobe refused", 32'(s_dacc), 0);
    @(posedge clk);
    @(negedge clk);
    m_dval = 1'b0;
    do_read(8'h00, 3'd1, 32'hDEAD_BEEF, 0);

    // R10: out-of-range write does not alias
    do_write(8'h12, 32'h7777_7777, 0);
    do_read(8'h02, 3'd1, 32'h0, 0);
    do_read(8'h12, 3'd3, 32'h0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule